// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Deferred Credit

This block sits beside the command arbiter of a DDR SDRAM controller and decides when an AUTO REFRESH goes out. A free-running interval timer, loaded from a programmable cycles-per-interval value, adds one refresh to a signed debt counter at every interval boundary. While the arbiter reports traffic, refreshes are postponed and the debt grows. Once the debt reaches the postponement ceiling, the block forces a refresh ahead of normal traffic.

To issue a refresh the block first asks the arbiter to close every bank. It waits until the arbiter reports all banks closed, then pulses the refresh command. Starting in that cycle it holds a command blackout and a clock-enable hold for the programmed refresh cycle time. When the bus is quiet and several refreshes are owed, they are paid back one after another, each separated by a full refresh window. No address is produced, because the device chooses the row itself during a refresh.

The ceiling on the gap between refreshes is a parameter counted in intervals. The default of nine allows eight owed refreshes. Setting it to eight gives the stricter limit of seven owed.

Top module: `refresh_sched`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `ref_cmd`, `pre_all_req`, `cmd_block`, `cke_hold`, `ref_req` and `ref_urgent` are 0 and `owed_count` is 0.
- R2: With `cfg_interval` = N (N at least 2), the owed count goes up by exactly one every N clock cycles, provided no refresh is issued in that span.
- R3: `ref_req` is 1 exactly when the owed count is at least 1.
- R4: While `bus_busy` is 1 and the owed count is below the ceiling, no refresh sequence starts: `pre_all_req` and `ref_cmd` stay 0.
- R5: The ceiling is MAX_GAP-1, which is 8 by default. `ref_urgent` is 1 exactly when the owed count equals the ceiling. In the cycle after that, `pre_all_req` rises even if `bus_busy` is 1. The owed count never exceeds the ceiling, provided the banks close within one interval.
- R6: `ref_cmd` is a one-cycle pulse. It occurs only in the cycle after one in which `pre_all_req` was 1 and `banks_idle` was sampled 1. While `banks_idle` stays 0, `pre_all_req` holds and no refresh is issued.
- R7: `cmd_block` and `cke_hold` are 1 for exactly `cfg_trfc` cycles, starting in the `ref_cmd` cycle, and are 0 in the cycle after that window. No `ref_cmd` falls within `cfg_trfc` cycles of the previous one.
- R8: Each `ref_cmd` lowers the owed count by one at the next edge. If an interval boundary and a `ref_cmd` fall in the same cycle, the count is unchanged.
- R9: With `bus_busy` at 0 and `banks_idle` held at 1, owed refreshes are issued back to back, with consecutive `ref_cmd` pulses exactly `cfg_trfc`+2 cycles apart, until the count reaches 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_interval | input | CNT_W | Clock cycles per average refresh interval (at least 2) |
| cfg_trfc | input | TRFC_W | Refresh cycle time in clocks (at least 1) |
| bus_busy | input | 1 | Arbiter has normal traffic pending |
| banks_idle | input | 1 | Every bank is precharged |
| ref_req | output | 1 | Low-priority request: at least one refresh owed |
| ref_urgent | output | 1 | Debt at ceiling: refresh preempts traffic |
| pre_all_req | output | 1 | Ask arbiter to precharge all banks |
| ref_cmd | output | 1 | One-cycle AUTO REFRESH issue strobe |
| cmd_block | output | 1 | No other command may be issued |
| cke_hold | output | 1 | Clock enable must stay high |
| owed_count | output | OWED_W | Number of refreshes currently owed |

## Verification
The interval boundary that adds debt and the refresh issue that pays debt off can land on the same clock edge. The bench observes the cycle in which the owed count rises at the port. From that point it counts one full interval and releases `banks_idle` so that the pending refresh is issued exactly in the cycle of the next boundary. It then expects the owed count to remain at 1, rather than rise to 2 or fall to 0.

// File: rtl/refsched_pkg.sv
package refsched_pkg;
  typedef enum logic [1:0] {
    RS_IDLE   = 2'd0,
    RS_PREALL = 2'd1,
    RS_BLOCK  = 2'd2
  } rs_state_t;
endpackage

// File: rtl/rs_interval_timer.sv
module rs_interval_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cfg_interval,
  output logic             tick
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= cfg_interval - 1'b1) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end

  AST_TICK_ISOLATED: assert property (@(posedge clk) disable iff (rst) tick |=> !tick); // R2
endmodule

// File: rtl/rs_owed_counter.sv
module rs_owed_counter #(
  parameter int OWED_W = 5,
  parameter int LIMIT  = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     tick,
  input  logic                     issue,
  output logic signed [OWED_W-1:0] owed,
  output logic                     pending,
  output logic                     urgent
);
  localparam logic signed [OWED_W-1:0] ZERO  = '0;
  localparam logic signed [OWED_W-1:0] ONE   = OWED_W'(1);
  localparam logic signed [OWED_W-1:0] LIM_S = OWED_W'(LIMIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      owed <= ZERO;
    end else begin
      case ({tick, issue})
        2'b10:   owed <= owed + ONE;
        2'b01:   owed <= owed - ONE;
        default: owed <= owed;
      endcase
    end
  end

  assign pending = (owed > ZERO);
  assign urgent  = (owed >= LIM_S);

  AST_OWED_LIMIT:    assert property (@(posedge clk) disable iff (rst) owed <= LIM_S); // R5
  AST_OWED_NONNEG:   assert property (@(posedge clk) disable iff (rst) owed >= ZERO); // R8
  AST_ISSUE_IN_DEBT: assert property (@(posedge clk) disable iff (rst) issue |-> $past(owed > ZERO)); // R8
endmodule

// File: rtl/rs_issue_fsm.sv
module rs_issue_fsm
  import refsched_pkg::*;
#(
  parameter int TRFC_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pending,
  input  logic              urgent,
  input  logic              bus_busy,
  input  logic              banks_idle,
  input  logic [TRFC_W-1:0] cfg_trfc,
  output logic              pre_all_req,
  output logic              ref_cmd,
  output logic              cmd_block
);
  rs_state_t         state;
  logic [TRFC_W-1:0] blk_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= RS_IDLE;
      pre_all_req <= 1'b0;
      ref_cmd     <= 1'b0;
      blk_cnt     <= '0;
    end else begin
      ref_cmd <= 1'b0;
      case (state)
        RS_IDLE: begin
          if (pending && (!bus_busy || urgent)) begin
            state       <= RS_PREALL;
            pre_all_req <= 1'b1;
          end
        end
        RS_PREALL: begin
          if (banks_idle) begin
            state       <= RS_BLOCK;
            pre_all_req <= 1'b0;
            ref_cmd     <= 1'b1;
            blk_cnt     <= cfg_trfc;
          end
        end
        RS_BLOCK: begin
          if (blk_cnt <= TRFC_W'(1)) state <= RS_IDLE;
          else                       blk_cnt <= blk_cnt - 1'b1;
        end
        default: state <= RS_IDLE;
      endcase
    end
  end

  assign cmd_block = (state == RS_BLOCK);

  AST_REF_AFTER_CLOSE:  assert property (@(posedge clk) disable iff (rst) ref_cmd |-> $past(pre_all_req && banks_idle)); // R6
  AST_REF_OUTSIDE_TRFC: assert property (@(posedge clk) disable iff (rst) ref_cmd |-> !$past(cmd_block)); // R7
  AST_BLOCK_FROM_REF:   assert property (@(posedge clk) disable iff (rst) $rose(cmd_block) |-> ref_cmd); // R7
  AST_URGENT_PREEMPTS:  assert property (@(posedge clk) disable iff (rst) (state == RS_IDLE && urgent) |=> pre_all_req); // R5
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched #(
  parameter int CNT_W   = 16,
  parameter int TRFC_W  = 10,
  parameter int MAX_GAP = 9,
  localparam int LIMIT  = MAX_GAP - 1,
  localparam int OWED_W = $clog2(MAX_GAP + 1) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  cfg_interval,
  input  logic [TRFC_W-1:0] cfg_trfc,
  input  logic              bus_busy,
  input  logic              banks_idle,
  output logic              ref_req,
  output logic              ref_urgent,
  output logic              pre_all_req,
  output logic              ref_cmd,
  output logic              cmd_block,
  output logic              cke_hold,
  output logic [OWED_W-1:0] owed_count
);
  logic                     tick;
  logic signed [OWED_W-1:0] owed;
  logic                     pending;
  logic                     urgent;

  rs_interval_timer #(.CNT_W(CNT_W)) u_timer (
    .clk          (clk),
    .rst          (rst),
    .cfg_interval (cfg_interval),
    .tick         (tick)
  );

  rs_owed_counter #(.OWED_W(OWED_W), .LIMIT(LIMIT)) u_owed (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .issue   (ref_cmd),
    .owed    (owed),
    .pending (pending),
    .urgent  (urgent)
  );

  rs_issue_fsm #(.TRFC_W(TRFC_W)) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .pending     (pending),
    .urgent      (urgent),
    .bus_busy    (bus_busy),
    .banks_idle  (banks_idle),
    .cfg_trfc    (cfg_trfc),
    .pre_all_req (pre_all_req),
    .ref_cmd     (ref_cmd),
    .cmd_block   (cmd_block)
  );

  assign ref_req    = pending;
  assign ref_urgent = urgent;
  assign cke_hold   = cmd_block;
  assign owed_count = $unsigned(owed);

  AST_NO_URGENT_IN_RESET: assert property (@(posedge clk) $past(rst) |-> !ref_urgent && !ref_req); // R1
endmodule

// File: tb/refresh_sched_tb.sv
`timescale 1ns/100ps
module refresh_sched_tb;
  localparam int CNT_W = 16, TRFC_W = 10, MAX_GAP = 9;
  localparam int LIMIT = MAX_GAP - 1;
  localparam int OW    = $clog2(MAX_GAP + 1) + 1;
  localparam int IVL   = 40;
  localparam int TRFC  = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [CNT_W-1:0]  cfg_interval = CNT_W'(IVL);
  logic [TRFC_W-1:0] cfg_trfc     = TRFC_W'(TRFC);
  logic bus_busy = 1'b1, banks_idle = 1'b0;
  logic ref_req, ref_urgent, pre_all_req, ref_cmd, cmd_block, cke_hold;
  logic [OW-1:0] owed_count;

  always #2.5 clk = ~clk;

  refresh_sched #(.CNT_W(CNT_W), .TRFC_W(TRFC_W), .MAX_GAP(MAX_GAP)) u_dut (
    .clk(clk), .rst(rst), .cfg_interval(cfg_interval), .cfg_trfc(cfg_trfc),
    .bus_busy(bus_busy), .banks_idle(banks_idle), .ref_req(ref_req),
    .ref_urgent(ref_urgent), .pre_all_req(pre_all_req), .ref_cmd(ref_cmd),
    .cmd_block(cmd_block), .cke_hold(cke_hold), .owed_count(owed_count)
  );

  typedef struct { int at; int val; string tag; } exp_t;
  exp_t sb_q[$];

  int n_checks = 0, n_fail = 0;
  int cyc = 0;
  int owed_i;
  bit done = 0, quiet = 0, drain = 0;
  int last_ref = -1, drain_last = -1, blk_left = 0;
  logic prev_pre = 1'b0, bi_at_edge = 1'b0;

  assign owed_i = int'(owed_count);

  always @(posedge clk) begin
    cyc        <= cyc + 1;
    bi_at_edge <= banks_idle;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic push_exp(input int at, input int val, input string tag);
    exp_t e;
    e.at = at; e.val = val; e.tag = tag;
    sb_q.push_back(e);
  endtask

  // Monitor: scoreboard pops and protocol checks, sampled at the falling edge
  always @(negedge clk) begin
    if (!rst) begin
      chk(ref_req == (owed_i >= 1), "R3", int'(ref_req), int'(owed_i >= 1));
      chk(ref_urgent == (owed_i == LIMIT), "R5", int'(ref_urgent), int'(owed_i == LIMIT));
      chk(owed_i <= LIMIT, "R5", owed_i, LIMIT);
      if (quiet && owed_i < LIMIT)
        chk(!pre_all_req && !ref_cmd, "R4", int'(pre_all_req | ref_cmd), 0);
      if (ref_cmd) begin
        chk(prev_pre && bi_at_edge, "R6", int'(prev_pre && bi_at_edge), 1);
        if (last_ref >= 0) chk(cyc - last_ref >= TRFC, "R7", cyc - last_ref, TRFC);
        if (drain && drain_last >= 0) chk(cyc - drain_last == TRFC + 2, "R9", cyc - drain_last, TRFC + 2);
        last_ref = cyc;
        if (drain) drain_last = cyc;
        blk_left = TRFC;
      end
      if (blk_left > 0) begin
        chk(cmd_block && cke_hold, "R7", int'(cmd_block && cke_hold), 1);
        blk_left--;
      end else if (last_ref >= 0 && cyc == last_ref + TRFC) begin
        chk(!cmd_block && !cke_hold, "R7", int'(cmd_block | cke_hold), 0);
      end
      while (sb_q.size() > 0 && sb_q[0].at <= cyc) begin
        exp_t e;
        e = sb_q.pop_front();
        chk(e.at == cyc && owed_i == e.val, e.tag, owed_i, e.val);
      end
      prev_pre = pre_all_req;
    end
  end

  initial begin
    repeat (3) step();
    // R1: reset state
    chk(!ref_cmd && !pre_all_req && !cmd_block && !cke_hold, "R1", int'(ref_cmd | pre_all_req | cmd_block | cke_hold), 0);
    chk(owed_i == 0 && !ref_req && !ref_urgent, "R1", owed_i, 0);
    rst = 1'b0;
    quiet = 1;
    step();
    chk(owed_i == 0 && !ref_req, "R1", owed_i, 0);

    // R2: debt grows one per interval while traffic defers refresh
    while (owed_i != 1) step();
    push_exp(cyc + IVL, 2, "R2");
    push_exp(cyc + 3 * IVL, 4, "R2");

    // R5: ceiling reached, refresh forced despite traffic
    while (owed_i != LIMIT) step();
    quiet = 0;
    step();
    step();
    chk(pre_all_req == 1'b1, "R5", int'(pre_all_req), 1);
    chk(ref_urgent == 1'b1, "R5", int'(ref_urgent), 1);
    // R6: no refresh while banks stay open
    repeat (4) step();
    chk(!ref_cmd && pre_all_req, "R6", int'(ref_cmd), 0);
    banks_idle = 1'b1;
    while (!ref_cmd) step();
    step();
    chk(owed_i == LIMIT - 1, "R8", owed_i, LIMIT - 1);

    // R9: drain back to back on an idle bus
    drain_last = -1;
    drain = 1;
    bus_busy = 1'b0;
    while (owed_i != 0) step();
    drain = 0;
    banks_idle = 1'b0;

    // R8: interval boundary and refresh issue in the same cycle
    while (owed_i != 1) step();
    repeat (IVL - 2) step();
    chk(pre_all_req == 1'b1 && !ref_cmd, "R6", int'(pre_all_req), 1);
    banks_idle = 1'b1;
    step();
    chk(ref_cmd == 1'b1, "R8", int'(ref_cmd), 1);
    banks_idle = 1'b0;
    push_exp(cyc + 1, 1, "R8");
    repeat (3) step();

    // final drain and quiet tail
    banks_idle = 1'b1;
    while (owed_i != 0) step();
    repeat (TRFC + 4) step();
    chk(!cmd_block && !pre_all_req, "R7", int'(cmd_block | pre_all_req), 0);
    chk(sb_q.size() == 0, "R2", sb_q.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule